// File: doc/BRIEF.md
# Flash Command Snooper and Bit Striper

This block sits between a transmit byte queue and two serial buses that each drive one flash memory of a paired arrangement. At the start of every chip-select period it inspects the first byte as an opcode. From that opcode it works out how many address and dummy bytes follow. While those bytes are in flight, every byte goes to both buses unchanged. Once the countdown expires, the block switches to striping: each pair of queued data bytes is bit-interleaved into one byte per bus, and the pair of bytes that comes back is de-interleaved before it enters the receive queue.

Transmit bytes are written into an internal queue. Each transfer starts on a request. The block then presents one byte per bus with a single-cycle start pulse and waits for a completion pulse that carries the returned bytes. Received bytes are held in a second queue, whose head is always visible and which is drained by a read strobe. Raising the chip-select-idle input returns the snooper to opcode inspection. Single-cycle event pulses flag a transfer request that the transmit queue cannot supply and a result that the receive queue cannot take.

Top module: `flash_stripe_snoop`

## Requirements
- R1: After reset the receive queue is empty (rx_empty=1), tx_full=0, bus_go=0, ovf_evt=0 and unf_evt=0, and the first byte transferred is treated as an opcode.
- R2: An opcode of 0x02, 0x03, 0x32 or 0xA2 is followed by exactly 3 pass-through transfers. Every later transfer in the same chip-select period is striped.
- R3: An opcode of 0x0B, 0x3B, 0x6B or 0xBB is followed by exactly 4 pass-through transfers, then striping.
- R4: An opcode of 0xEB is followed by exactly 6 pass-through transfers, then striping.
- R5: Any other opcode leaves every transfer as pass-through until chip select goes idle.
- R6: A pass-through transfer takes one byte from the transmit queue and drives it on both bus_out0 and bus_out1. Only bus_in0 is pushed into the receive queue.
- R7: A striped transfer takes two bytes, A and then B. For k=0..3 it drives bus_out0[2k]=A[k], bus_out0[2k+1]=B[k], bus_out1[2k]=A[k+4] and bus_out1[2k+1]=B[k+4].
- R8: A striped result is de-interleaved and pushed as two bytes, X and then Y. For k=0..3, X[k]=bus_in0[2k], Y[k]=bus_in0[2k+1], X[k+4]=bus_in1[2k] and Y[k+4]=bus_in1[2k+1].
- R9: A high cs_idle returns the snooper to opcode inspection in the next cycle. A transfer request in the same cycle is ignored and raises no event.
- R10: If the receive queue lacks room for the whole result, nothing is pushed and ovf_evt pulses high for one cycle, in the cycle after bus_done.
- R11: If the transmit queue holds fewer bytes than a transfer needs, nothing is popped, no bus_go is issued, and unf_evt pulses high in the cycle after the request.
- R12: With dual_bus low, the snooper still counts, but every transfer behaves as pass-through.
- R13: bus_go is a one-cycle pulse in the cycle after an accepted request. Requests made while a transfer awaits bus_done are ignored.
- R14: A tx_wr while tx_full is high is ignored and does not enter the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_idle | input | 1 | No chip select active; return to opcode inspection |
| dual_bus | input | 1 | Both buses active (enables striping) |
| tx_wr | input | 1 | Write tx_byte into the transmit queue |
| tx_byte | input | 8 | Transmit byte |
| tx_full | output | 1 | Transmit queue full |
| xfer_req | input | 1 | Request one transfer step |
| bus_go | output | 1 | Start pulse for a bus transfer |
| bus_out0 | output | 8 | Byte for bus 0 |
| bus_out1 | output | 8 | Byte for bus 1 |
| bus_done | input | 1 | Transfer complete; returned bytes valid |
| bus_in0 | input | 8 | Byte returned by bus 0 |
| bus_in1 | input | 8 | Byte returned by bus 1 |
| rx_rd | input | 1 | Pop the head of the receive queue |
| rx_byte | output | 8 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| ovf_evt | output | 1 | Receive overflow event pulse |
| unf_evt | output | 1 | Transmit underflow event pulse |

## Verification
The hardest situation to reach is a request that arrives after the countdown has expired, with exactly one byte left in the transmit queue: the queue holds a byte, yet a striped transfer cannot be served. The stimulus reaches it by pushing an opcode, exactly its count of address bytes and one odd data byte. It then uses the same odd state to test that cs_idle wins over a simultaneous request. All 256 opcode values are swept with both buses and again with one bus. A model in the bench tracks the countdown and computes every interleaved byte and every de-interleaved byte from the bit formulas.

// File: rtl/flash_snoop_pkg.sv
package flash_snoop_pkg;
  localparam int BYTE_W = 8;
  localparam int HALF_W = BYTE_W / 2;
  localparam int CNT_W  = 3;

  typedef enum logic [1:0] {SN_CHECK, SN_COUNT, SN_NONE, SN_STRIPE} snoop_mode_t;
  typedef enum logic {PH_IDLE, PH_WAIT} phase_t;

  // Number of address/dummy bytes that follow an opcode; zero for unknown opcodes.
  function automatic logic [CNT_W-1:0] lead_bytes(input logic [BYTE_W-1:0] op);
    case (op)
      8'h03, 8'h02, 8'hA2, 8'h32: lead_bytes = CNT_W'(3);
      8'h0B, 8'h3B, 8'h6B, 8'hBB: lead_bytes = CNT_W'(4);
      8'hEB:                      lead_bytes = CNT_W'(6);
      default:                    lead_bytes = '0;
    endcase
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo import flash_snoop_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        push_n,
  input  logic [BYTE_W-1:0] d0,
  input  logic [BYTE_W-1:0] d1,
  input  logic [1:0]        pop_n,
  output logic [BYTE_W-1:0] q0,
  output logic [BYTE_W-1:0] q1,
  output logic [CW-1:0]     count
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push_n != 2'd0) mem[wp] <= d0;
    if (push_n == 2'd2) mem[wp + AW'(1)] <= d1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      wp    <= wp + AW'(push_n);
      rp    <= rp + AW'(pop_n);
      count <= count + CW'(push_n) - CW'(pop_n);
    end
  end

  assign q0 = mem[rp];
  assign q1 = mem[rp + AW'(1)];

  // R10
  fifo_room_chk: assert property (@(posedge clk) disable iff (rst)
    (push_n != 2'd0) |-> (({1'b0, count} + (CW+1)'(push_n)) <= (CW+1)'(DEPTH)));
  // R11
  fifo_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_n != 2'd0) |-> (CW'(pop_n) <= count));
endmodule

// File: rtl/lane_mix.sv
module lane_mix import flash_snoop_pkg::*; (
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  input  logic [BYTE_W-1:0] r0,
  input  logic [BYTE_W-1:0] r1,
  output logic [BYTE_W-1:0] s0,
  output logic [BYTE_W-1:0] s1,
  output logic [BYTE_W-1:0] u0,
  output logic [BYTE_W-1:0] u1
);
  // s0/s1: interleave the low/high nibbles of a and b; u0/u1: the inverse.
  for (genvar k = 0; k < HALF_W; k++) begin : g_bit
    assign s0[2*k]        = a[k];
    assign s0[2*k+1]      = b[k];
    assign s1[2*k]        = a[k+HALF_W];
    assign s1[2*k+1]      = b[k+HALF_W];
    assign u0[k]          = r0[2*k];
    assign u1[k]          = r0[2*k+1];
    assign u0[k+HALF_W]   = r1[2*k];
    assign u1[k+HALF_W]   = r1[2*k+1];
  end
endmodule

// File: rtl/snoop_fsm.sv
module snoop_fsm import flash_snoop_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_idle,
  input  logic              step,
  input  logic [BYTE_W-1:0] op,
  output logic              striping
);
  snoop_mode_t      mode;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lead;

  assign lead = lead_bytes(op);

  always_ff @(posedge clk) begin
    if (rst || cs_idle) begin
      mode <= SN_CHECK;
      cnt  <= '0;
    end else if (step) begin
      unique case (mode)
        SN_CHECK: begin
          cnt  <= lead;
          mode <= (lead == '0) ? SN_NONE : SN_COUNT;
        end
        SN_COUNT: begin
          cnt <= cnt - CNT_W'(1);
          if (cnt == CNT_W'(1)) mode <= SN_STRIPE;
        end
        default: ;
      endcase
    end
  end

  assign striping = (mode == SN_STRIPE);

  // R9
  idle_check_chk: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> (mode == SN_CHECK));
  // R2
  stripe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == SN_STRIPE && !cs_idle) |=> (mode == SN_STRIPE));
  // R5
  none_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == SN_NONE && !cs_idle) |=> (mode == SN_NONE));
  // R4
  count_live_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == SN_COUNT) |-> (cnt != '0));
endmodule

// File: rtl/flash_stripe_snoop.sv
module flash_stripe_snoop import flash_snoop_pkg::*; #(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  localparam int TCW = $clog2(TX_DEPTH) + 1,
  localparam int RCW = $clog2(RX_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_idle,
  input  logic              dual_bus,
  input  logic              tx_wr,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              tx_full,
  input  logic              xfer_req,
  output logic              bus_go,
  output logic [BYTE_W-1:0] bus_out0,
  output logic [BYTE_W-1:0] bus_out1,
  input  logic              bus_done,
  input  logic [BYTE_W-1:0] bus_in0,
  input  logic [BYTE_W-1:0] bus_in1,
  input  logic              rx_rd,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_empty,
  output logic              ovf_evt,
  output logic              unf_evt
);
  phase_t            phase;
  logic              pend_str, striping, stripe_now, want, issue, arrive, rx_room;
  logic [1:0]        need, tx_push_n, tx_pop_n, rx_need, rx_push_n, rx_pop_n;
  logic [TCW-1:0]    tx_count;
  logic [RCW-1:0]    rx_count;
  logic [BYTE_W-1:0] tx_h0, tx_h1, mix0, mix1, un0, un1, rx_d0, rx_h1_unused;

  assign stripe_now = striping && dual_bus;
  assign need       = stripe_now ? 2'd2 : 2'd1;
  assign want       = (phase == PH_IDLE) && xfer_req && !cs_idle;
  assign issue      = want && (tx_count >= TCW'(need));
  assign tx_full    = (tx_count == TCW'(TX_DEPTH));
  assign tx_push_n  = {1'b0, tx_wr && !tx_full};
  assign tx_pop_n   = issue ? need : 2'd0;

  assign arrive     = (phase == PH_WAIT) && bus_done;
  assign rx_need    = pend_str ? 2'd2 : 2'd1;
  assign rx_room    = ({1'b0, rx_count} + (RCW+1)'(rx_need)) <= (RCW+1)'(RX_DEPTH);
  assign rx_push_n  = (arrive && rx_room) ? rx_need : 2'd0;
  assign rx_d0      = pend_str ? un0 : bus_in0;
  assign rx_empty   = (rx_count == '0);
  assign rx_pop_n   = {1'b0, rx_rd && !rx_empty};

  byte_fifo #(.DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push_n(tx_push_n), .d0(tx_byte), .d1(tx_byte),
    .pop_n(tx_pop_n), .q0(tx_h0), .q1(tx_h1), .count(tx_count));

  byte_fifo #(.DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push_n(rx_push_n), .d0(rx_d0), .d1(un1),
    .pop_n(rx_pop_n), .q0(rx_byte), .q1(rx_h1_unused), .count(rx_count));

  lane_mix u_mix (
    .a(tx_h0), .b(tx_h1), .r0(bus_in0), .r1(bus_in1),
    .s0(mix0), .s1(mix1), .u0(un0), .u1(un1));

  snoop_fsm u_snoop (
    .clk(clk), .rst(rst), .cs_idle(cs_idle), .step(issue), .op(tx_h0),
    .striping(striping));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      pend_str <= 1'b0;
      bus_go   <= 1'b0;
      bus_out0 <= '0;
      bus_out1 <= '0;
      ovf_evt  <= 1'b0;
      unf_evt  <= 1'b0;
    end else begin
      bus_go  <= issue;
      unf_evt <= want && !issue;
      ovf_evt <= arrive && !rx_room;
      if (issue) begin
        phase    <= PH_WAIT;
        pend_str <= stripe_now;
        bus_out0 <= stripe_now ? mix0 : tx_h0;
        bus_out1 <= stripe_now ? mix1 : tx_h0;
      end else if (arrive) begin
        phase <= PH_IDLE;
      end
    end
  end

  // R13
  go_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    bus_go |=> !bus_go);
  // R11
  unf_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    unf_evt |-> !bus_go);
  // R10
  ovf_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt && !$past(rx_rd)) |-> $stable(rx_count));
  // R6
  dup_bytes_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_go && !pend_str) |-> (bus_out0 == bus_out1));
endmodule

// File: tb/sim_flash_stripe_snoop.sv
module sim_flash_stripe_snoop;
  localparam int TXD = 16;
  localparam int RXD = 16;

  logic clk = 1'b0, rst = 1'b1, cs_idle = 1'b0, dual_bus = 1'b1;
  logic tx_wr = 1'b0, xfer_req = 1'b0, bus_done = 1'b0, rx_rd = 1'b0;
  logic [7:0] tx_byte = '0, bus_in0 = '0, bus_in1 = '0;
  logic tx_full, bus_go, rx_empty, ovf_evt, unf_evt;
  logic [7:0] bus_out0, bus_out1, rx_byte;

  flash_stripe_snoop #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u0 (
    .clk(clk), .rst(rst), .cs_idle(cs_idle), .dual_bus(dual_bus),
    .tx_wr(tx_wr), .tx_byte(tx_byte), .tx_full(tx_full),
    .xfer_req(xfer_req), .bus_go(bus_go), .bus_out0(bus_out0), .bus_out1(bus_out1),
    .bus_done(bus_done), .bus_in0(bus_in0), .bus_in1(bus_in1),
    .rx_rd(rx_rd), .rx_byte(rx_byte), .rx_empty(rx_empty),
    .ovf_evt(ovf_evt), .unf_evt(unf_evt));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  int m_mode = 0, m_cnt = 0;  // 0 inspect, 1 counting, 2 pass-through, 3 striping

  function automatic int opc_len(input logic [7:0] op);
    case (op)
      8'h03, 8'h02, 8'hA2, 8'h32: return 3;
      8'h0B, 8'h3B, 8'h6B, 8'hBB: return 4;
      8'hEB: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] ilv(input logic [7:0] a, input logic [7:0] b, input int hi);
    logic [7:0] r;
    for (int k = 0; k < 4; k++) begin
      r[2*k]   = a[k + 4*hi];
      r[2*k+1] = b[k + 4*hi];
    end
    return r;
  endfunction

  function automatic logic [7:0] deil(input logic [7:0] r0, input logic [7:0] r1, input int which);
    logic [7:0] v;
    for (int k = 0; k < 4; k++) begin
      v[k]   = r0[2*k + which];
      v[k+4] = r1[2*k + which];
    end
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    tx_byte = b; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    if (txq.size() < TXD) txq.push_back(b);
  endtask

  task automatic idle();
    cs_idle = 1'b1;
    @(negedge clk);
    cs_idle = 1'b0;
    m_mode = 0; m_cnt = 0;
  endtask

  task automatic xfer(input string tag, input bit poke = 0);
    bit st; int nd, l;
    logic [7:0] a, b, e0, e1, r0, r1;
    string rq;
    st = (m_mode == 3) && dual_bus;
    nd = st ? 2 : 1;
    xfer_req = 1'b1;
    @(negedge clk);
    xfer_req = 1'b0;
    if (txq.size() < nd) begin
      chk($sformatf("R11 underflow %s", tag), {30'd0, unf_evt, bus_go}, 32'd2);
      return;
    end
    a = txq.pop_front();
    b = st ? txq.pop_front() : a;
    e0 = st ? ilv(a, b, 0) : a;
    e1 = st ? ilv(a, b, 1) : a;
    rq = st ? "R7" : "R6";
    chk($sformatf("%s bus bytes %s", rq, tag), {14'd0, unf_evt, bus_go, bus_out0, bus_out1},
        {14'd0, 1'b0, 1'b1, e0, e1});
    if (m_mode == 0) begin
      l = opc_len(a); m_cnt = l; m_mode = (l == 0) ? 2 : 1;
    end else if (m_mode == 1) begin
      m_cnt--; if (m_cnt == 0) m_mode = 3;
    end
    if (poke) begin
      xfer_req = 1'b1;
      @(negedge clk);
      xfer_req = 1'b0;
      chk("R13 request while waiting", {31'd0, bus_go}, 32'd0);
    end
    r0 = bus_out0 ^ 8'h5A;
    r1 = bus_out1 ^ 8'hC3;
    bus_in0 = r0; bus_in1 = r1; bus_done = 1'b1;
    @(negedge clk);
    bus_done = 1'b0;
    chk("R13 single pulse", {31'd0, bus_go}, 32'd0);
    if (rxq.size() + nd > RXD) begin
      chk($sformatf("R10 overflow %s", tag), {31'd0, ovf_evt}, 32'd1);
    end else begin
      chk($sformatf("R10 no overflow %s", tag), {31'd0, ovf_evt}, 32'd0);
      if (st) begin
        rxq.push_back(deil(r0, r1, 0));
        rxq.push_back(deil(r0, r1, 1));
      end else begin
        rxq.push_back(r0);
      end
    end
  endtask

  task automatic drain(input string tag);
    while (rxq.size() > 0) begin
      chk($sformatf("R8/R6 rx data %s", tag), {23'd0, rx_empty, rx_byte}, {23'd0, 1'b0, rxq[0]});
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
      void'(rxq.pop_front());
    end
    chk($sformatf("R8 rx empty %s", tag), {31'd0, rx_empty}, 32'd1);
  endtask

  task automatic session(input logic [7:0] op, input bit dual);
    int l, n;
    string tag;
    dual_bus = dual;
    idle();
    l = opc_len(op);
    if (!dual) tag = "R12";
    else if (l == 3) tag = "R2";
    else if (l == 4) tag = "R3";
    else if (l == 6) tag = "R4";
    else tag = "R5";
    tag = $sformatf("%s op %h", tag, op);
    push(op);
    n = (l == 0) ? 4 : l + 4;
    for (int i = 0; i < n; i++) push(op ^ 8'((i * 37) + 1));
    while (txq.size() > 0) xfer(tag);
    drain(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset state", {27'd0, rx_empty, tx_full, bus_go, ovf_evt, unf_evt}, 32'h10);
    xfer("R11 empty after reset");

    for (int op = 0; op < 256; op++) session(op[7:0], 1'b1);
    for (int op = 0; op < 256; op++) session(op[7:0], 1'b0);

    // striped request with a single queued byte
    dual_bus = 1'b1;
    idle();
    push(8'h03); push(8'h11); push(8'h22); push(8'h33); push(8'h44);
    repeat (4) xfer("R2 stripe setup");
    xfer("R11 one byte while striping");
    // cs_idle wins over a simultaneous request
    cs_idle = 1'b1; xfer_req = 1'b1;
    @(negedge clk);
    cs_idle = 1'b0; xfer_req = 1'b0;
    m_mode = 0; m_cnt = 0;
    chk("R9 request ignored under idle", {30'd0, bus_go, unf_evt}, 32'd0);
    xfer("R9 byte treated as opcode");
    drain("R9");

    // request while waiting for completion
    idle();
    push(8'h9F); push(8'h11);
    xfer("R13", 1'b1);
    xfer("R13 next byte");
    drain("R13");

    // full transmit queue and receive overflow
    idle();
    push(8'h9F);
    for (int i = 1; i < 16; i++) push(8'(i + 100));
    chk("R14 full flag", {31'd0, tx_full}, 32'd1);
    push(8'hEE);
    repeat (16) xfer("R10 fill");
    xfer("R14 dropped write");
    push(8'h77);
    xfer("R10 full receive queue");
    drain("R10");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule